// File: doc/BRIEF.md
# Cable Identification Pulse Counter

This block identifies which cable is plugged into each of two input connectors. A remote source sends repeated bursts of 1 to 31 pulses on an identification line per connector. The block counts the pulses in each burst and keeps the most recent count in a 5-bit register for each connector. A bus master reads either register with a single read request, and every such read is acknowledged.

The first rising edge after idle opens a fixed counting window. The window is `WIN_CYC` system clocks long, which is slightly longer than the longest burst can take. When the window closes, the count moves into that connector's register and the counter starts again from zero. A separate inactivity timer restarts on every rising edge. If no edge arrives for `DEAD_CYC` clocks, the register is cleared, and it reads zero until a new burst finishes. `DEAD_CYC` must be much larger than `WIN_CYC`.

Top module: `cable_id_decoder`

## Requirements
- R1: Each identification input passes through two synchronizing flops. A pulse is counted once, on its low-to-high transition, however long it stays high.
- R2: The first rising edge seen while a channel is idle opens a window of `WIN_CYC` clocks, and that edge counts as pulse 1.
- R3: When the window closes, the count is copied into the channel's register, the counter returns to zero, and the next rising edge starts a new burst.
- R4: The count stops at 31. Further pulses in the same window do not change it.
- R5: Each rising edge restarts a `DEAD_CYC`-clock inactivity timer. The register keeps its value while edges keep arriving. When the timer expires, the register is cleared to 0, and it stays 0 until the next window closes.
- R6: In the clock after a read request, `rd_ack` is 1 and `rd_data` holds the selected register. `rd_req[0]` selects connector A and `rd_req[1]` selects connector B. If both bits are set, connector A wins.
- R7: In the clock after a cycle with no read request, `rd_ack` and `rd_data` are both 0.
- R8: After reset, both registers are 0, `rd_ack` is 0 and no burst is in progress.
- R9: The two channels are independent. Activity on one input never changes the other channel's register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| id_in | input | 2 | Identification lines, bit 0 connector A, bit 1 connector B |
| rd_req | input | 2 | Read request, bit 0 connector A, bit 1 connector B |
| rd_ack | output | 1 | Read acknowledge, registered |
| rd_data | output | 5 | Read data, registered |

## Verification
An input edge reaches the counting logic two clocks after the input changes, and the register updates on the clock where the window closes, `WIN_CYC` clocks after the first counted edge. A register clears `DEAD_CYC` clocks after that channel's last edge. Read results appear one clock after the request. The bench keeps a behavioural model driven by the same input samples and compares both outputs with it on the falling edge of every clock. It also checks scenario reads against fixed counts, and each of those reads is made well after the window has closed, so the expected value is no longer changing.

// File: rtl/cid_pkg.sv
package cid_pkg;
  localparam int CNT_W   = 5;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/cid_sync_edge.sv
module cid_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] pipe;

  genvar i;
  generate
    for (i = 0; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= 1'b0;
        else if (i == 0) pipe[i] <= din;
        else pipe[i] <= pipe[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  // synchronized level high now, low one clock before
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/cid_burst_counter.sv
module cid_burst_counter
  import cid_pkg::*;
#(
  parameter int WIN_CYC = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic clr_held,
  output cnt_t held
);
  localparam int TW = $clog2(WIN_CYC + 1);

  logic          active;
  logic [TW-1:0] tmr;
  cnt_t          cnt;
  logic          closing;

  assign closing = active && (tmr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      tmr    <= '0;
      cnt    <= '0;
    end else if (!active || closing) begin
      if (rise) begin
        active <= 1'b1;
        tmr    <= TW'(WIN_CYC - 1);
        cnt    <= cnt_t'(1);
      end else begin
        active <= 1'b0;
        cnt    <= '0;
      end
    end else begin
      tmr <= tmr - 1'b1;
      if (rise && cnt != cnt_t'(CNT_MAX)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           held <= '0;
    else if (closing)  held <= cnt;
    else if (clr_held) held <= '0;
  end
endmodule

// File: rtl/cid_dead_timer.sv
module cid_dead_timer #(
  parameter int DEAD_CYC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  output logic expire
);
  localparam int TW = $clog2(DEAD_CYC + 1);

  logic          alive;
  logic [TW-1:0] tmr;

  assign expire = alive && (tmr == '0) && !rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      alive <= 1'b0;
      tmr   <= '0;
    end else if (rise) begin
      alive <= 1'b1;
      tmr   <= TW'(DEAD_CYC - 1);
    end else if (alive) begin
      if (tmr == '0) alive <= 1'b0;
      else tmr <= tmr - 1'b1;
    end
  end
endmodule

// File: rtl/cable_id_decoder.sv
module cable_id_decoder
  import cid_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int WIN_CYC  = 256,
  parameter int DEAD_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   id_in,
  input  logic [NCH-1:0]   rd_req,
  output logic             rd_ack,
  output logic [CNT_W-1:0] rd_data
);
  logic [NCH*CNT_W-1:0] held_all;
  logic [NCH-1:0]       rise_all;
  logic [NCH-1:0]       dead_exp;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      cnt_t held_c;
      cid_sync_edge #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(id_in[c]), .rise(rise_all[c]));
      cid_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk(clk), .rst(rst), .rise(rise_all[c]), .expire(dead_exp[c]));
      cid_burst_counter #(.WIN_CYC(WIN_CYC)) u_cnt (
        .clk(clk), .rst(rst), .rise(rise_all[c]),
        .clr_held(dead_exp[c]), .held(held_c));
      assign held_all[c*CNT_W +: CNT_W] = held_c;
    end
  endgenerate

  cnt_t sel_data;
  always_comb begin
    sel_data = '0;
    for (int k = NCH-1; k >= 0; k--)
      if (rd_req[k]) sel_data = held_all[k*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack  <= |rd_req;
      rd_data <= sel_data;
    end
  end
endmodule

// File: rtl/cid_checker.sv
module cid_checker #(
  parameter int NCH   = 2,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   rd_req,
  input logic             rd_ack,
  input logic [CNT_W-1:0] rd_data,
  input logic [NCH*CNT_W-1:0] held_all,
  input logic [NCH-1:0]   dead_exp
);
  p_ack_on_read_r6: assert property (@(posedge clk) disable iff (rst)
    (|rd_req) |=> rd_ack);

  p_read_a_value_r6: assert property (@(posedge clk) disable iff (rst)
    rd_req[0] |=> rd_data == $past(held_all[CNT_W-1:0]));

  p_idle_bus_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_req == '0) |=> (!rd_ack && rd_data == '0));

  p_reset_quiet_r8: assert property (@(posedge clk)
    $past(rst) |-> !rd_ack);

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_chk
      p_dead_clear_r5: assert property (@(posedge clk) disable iff (rst)
        dead_exp[c] |=> held_all[c*CNT_W +: CNT_W] == '0);
    end
  endgenerate
endmodule

bind cable_id_decoder cid_checker #(.NCH(NCH), .CNT_W(cid_pkg::CNT_W)) u_cid_checker (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
  .held_all(held_all), .dead_exp(dead_exp));

// File: tb/cable_id_decoder_bench.sv
module cable_id_decoder_bench;
  localparam int CLK_PER = 10;
  localparam int WIN     = 160;
  localparam int DEAD    = 600;
  localparam int LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] id_in = 2'b00;
  logic [1:0] rd_req = 2'b00;
  logic       rd_ack;
  logic [4:0] rd_data;

  int total = 0;
  int bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  cable_id_decoder #(.NCH(2), .WIN_CYC(WIN), .DEAD_CYC(DEAD)) u_cable_id_decoder (
    .clk(clk), .rst(rst), .id_in(id_in), .rd_req(rd_req),
    .rd_ack(rd_ack), .rd_data(rd_data));

  // behavioural reference model
  int m_act[2], m_tm[2], m_cnt[2], m_held[2], m_alive[2], m_dt[2];
  bit m_h0[2], m_h1[2], m_h2[2];
  int exp_ack, exp_data;

  always @(posedge clk) begin
    if (rst) begin
      exp_ack = 0; exp_data = 0;
      for (int c = 0; c < 2; c++) begin
        m_act[c] = 0; m_tm[c] = 0; m_cnt[c] = 0; m_held[c] = 0;
        m_alive[c] = 0; m_dt[c] = 0; m_h0[c] = 0; m_h1[c] = 0; m_h2[c] = 0;
      end
    end else begin
      exp_ack  = (rd_req != 0) ? 1 : 0;
      exp_data = rd_req[0] ? m_held[0] : (rd_req[1] ? m_held[1] : 0);
      for (int c = 0; c < 2; c++) begin
        bit r, close, dex;
        r     = m_h1[c] && !m_h2[c];
        close = (m_act[c] != 0) && (m_tm[c] == 0);
        dex   = (m_alive[c] != 0) && (m_dt[c] == 0) && !r;
        if (close) m_held[c] = m_cnt[c];
        else if (dex) m_held[c] = 0;
        if (m_act[c] == 0 || close) begin
          if (r) begin m_act[c] = 1; m_tm[c] = WIN - 1; m_cnt[c] = 1; end
          else begin m_act[c] = 0; m_cnt[c] = 0; end
        end else begin
          m_tm[c]--;
          if (r && m_cnt[c] < 31) m_cnt[c]++;
        end
        if (r) begin m_alive[c] = 1; m_dt[c] = DEAD - 1; end
        else if (m_alive[c] != 0) begin
          if (m_dt[c] == 0) m_alive[c] = 0; else m_dt[c]--;
        end
        m_h2[c] = m_h1[c]; m_h1[c] = m_h0[c]; m_h0[c] = id_in[c];
      end
    end
  end

  // per-clock comparison against the model (R6, R7)
  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (rd_ack !== exp_ack[0] || rd_data !== exp_data[4:0]) begin
        bad++;
        $display("FAIL R7 per-clock: ack=%0d data=%0d expected ack=%0d data=%0d",
                 rd_ack, rd_data, exp_ack, exp_data);
      end
    end
  end

  task automatic check(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(int na, int nb);
    int m;
    m = (na > nb) ? na : nb;
    for (int i = 0; i < m; i++) begin
      id_in = {(i < nb), (i < na)};
      idle(2);
      id_in = 2'b00;
      idle(2);
    end
  endtask

  task automatic read(logic [1:0] req, string tag, int expv);
    rd_req = req;
    @(negedge clk);
    rd_req = 2'b00;
    check({tag, " ack"}, rd_ack, 1);
    check({tag, " data"}, rd_data, expv);
  endtask

  initial begin
    idle(5);
    check("R8 ack after reset", rd_ack, 0);
    check("R8 data after reset", rd_data, 0);
    rst = 1'b0;
    idle(2);
    read(2'b01, "R8 register A zero", 0);
    idle(1);
    check("R7 idle ack", rd_ack, 0);

    pulses(5, 0); idle(WIN + 10);
    read(2'b01, "R2 R3 burst of 5", 5);
    read(2'b10, "R9 B untouched", 0);

    pulses(12, 7); idle(WIN + 10);
    read(2'b01, "R3 A new burst", 12);
    read(2'b10, "R9 B independent", 7);

    id_in = 2'b01; idle(60); id_in = 2'b00; idle(2);
    pulses(2, 0); idle(WIN + 10);
    read(2'b01, "R1 long high counts once", 3);

    pulses(35, 0); idle(WIN + 10);
    read(2'b01, "R4 saturate", 31);
    read(2'b11, "R6 both requested A wins", 31);

    pulses(0, 9); idle(WIN + 10); idle(300);
    read(2'b10, "R5 held while alive", 9);
    idle(DEAD);
    read(2'b10, "R5 cleared after inactivity", 0);
    read(2'b01, "R5 A cleared", 0);
    idle(5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule